// File: doc/BRIEF.md
# Random-Word Output Queue with Error Unit

This block is the read side of a random number generator. A producer hands it 64-bit random words over a simple valid/ready input, and the words wait in a small queue so that a host usually finds data ready. The host reads through a register-style port. Each read is 1, 4 or 8 bytes wide and names its byte lanes with a 3-bit address. The block tracks which lanes of the head word have been read. It retires the head word once every lane has been read, and the next word then becomes visible.

The block also contains an error unit with three error sources. A write into the queue window is an addressing error. A read of an empty queue is an underflow. A read of a lane that was already read is a double read. A mask register can suppress each source. An unmasked error is latched in a status register, which raises the interrupt output and halts the producer side until software clears the status. A second register-write path reaches the mask and the status registers, the soft-clear control and an end-of-message location. A write to the end-of-message location is accepted and has no effect. When the unit is assigned to a channel, a nonzero status also drives a channel error output.

Top module: `rng_out_fifo`

## Requirements
- R1: After reset the queue is empty (`level` 0, `rd_data` 0), the status and mask registers are 0, and `err_irq`, `halted` and `chan_err` are low while `src_ready` is high.
- R2: Words accepted with `src_valid && src_ready` are returned in arrival order. `rd_data` always shows the whole head word, and shows 0 when the queue is empty.
- R3: Lane masks are set by `rd_size`. 0 selects one byte at lane `rd_addr`. 1 selects lanes 0-3 when `rd_addr[2]` is 0 and lanes 4-7 otherwise. 2 or 3 selects all eight lanes. The head word is removed in the cycle its eighth lane is read, and not before.
- R4: A read that touches any lane already read from the current head word sets status bit 2 (double read). Its lanes still count toward retiring the word.
- R5: A pulse on `q_wr` (write into the queue window) sets status bit 0 (addressing error).
- R6: A read while the queue is empty sets status bit 1 (underflow) and leaves `level` unchanged.
- R7: An error whose mask bit is 1 leaves its status bit at 0 and raises no interrupt. The mask has the same bit layout as the status register (`reg_sel` 1).
- R8: A nonzero status drives `err_irq` and `halted` high one cycle after the error. While halted, `src_ready` is low and no word is accepted.
- R9: A status write (`reg_sel` 0) stores `reg_wdata & ~mask` and clears every other status bit.
- R10: A control write (`reg_sel` 3) with `reg_wdata[0]` set clears the whole status register.
- R11: `chan_err` is high exactly when `chan_assigned` is high and the status is nonzero.
- R12: A write to the end-of-message location (`reg_sel` 2) changes neither the status, the mask, the queue contents nor the lane tracking.
- R13: The queue holds `DEPTH` (8) words. When it is full, `src_ready` is low and further input words are refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_valid | input | 1 | Producer offers a word |
| src_data | input | 64 | Random word from producer |
| src_ready | output | 1 | Queue accepts a word this cycle |
| rd_en | input | 1 | Host read into the queue window |
| rd_size | input | 2 | Read width: 0 byte, 1 four bytes, 2/3 eight bytes |
| rd_addr | input | 3 | Byte lane address inside the head word |
| rd_data | output | 64 | Head word, zero when empty |
| q_wr | input | 1 | Host write into the queue window (always an error) |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 status, 1 mask, 2 end-of-message, 3 control |
| reg_wdata | input | 3 | Register write data |
| chan_assigned | input | 1 | Unit is bound to a channel |
| err_status | output | 3 | Status: bit0 address, bit1 underflow, bit2 double read |
| err_mask | output | 3 | Mask register, same layout |
| err_irq | output | 1 | Error interrupt |
| halted | output | 1 | Unit halted by an error |
| chan_err | output | 1 | Error flag toward the assigned channel |
| level | output | 4 | Number of words in the queue |

## Verification
A lane vector that is stuck or clears at the wrong time shows up within one read. The head word either retires early, which advances `rd_data` and decrements `level` after fewer than eight bytes, or it never retires, and reading a fresh lane then sets the double-read bit in the next cycle. A wrong status merge or mask handling is visible at `err_status` and `err_irq` one cycle after the offending access or register write. A halt that fails to engage is visible at once, because `src_ready` stays high. Ordering faults in the queue show as the wrong word on `rd_data` right after a retire.

// File: rtl/rof_pkg.sv
// Shared encodings for the random-word output queue.
// Assumes 64-bit words split into eight byte lanes.
package rof_pkg;
    localparam int LANES  = 8;
    localparam int STAT_W = 3;

    // Status and mask bit positions.
    localparam int BIT_ADDR = 0;
    localparam int BIT_UNDR = 1;
    localparam int BIT_DBL  = 2;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_QUAD = 2'b01,
        SZ_OCT  = 2'b10,
        SZ_OCT2 = 2'b11
    } rd_size_e;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'b00,
        SEL_MASK   = 2'b01,
        SEL_EOM    = 2'b10,
        SEL_CTRL   = 2'b11
    } reg_sel_e;
endpackage

// File: rtl/rof_queue.sv
// Circular word queue with push/pop and a live head view.
// Assumes the caller never pushes when full nor pops when empty.
module rof_queue #(
    parameter int WORD_W = 64,
    parameter int DEPTH  = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [WORD_W-1:0] push_data,
    input  logic              pop,
    output logic [WORD_W-1:0] head,
    output logic              empty,
    output logic              full,
    output logic [CNT_W-1:0]  count
);
    logic [WORD_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wptr, rptr;

    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    assign empty = (count == '0);
    assign full  = (count == FULL_CNT);
    assign head  = empty ? '0 : mem[rptr];

    // Write the storage slot addressed by the write pointer.
    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= push_data;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            if (pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    a_r13_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);
    a_r6_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !pop);
    a_r2_level_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);
endmodule

// File: rtl/rof_lane_track.sv
// Tracks consumed byte lanes of the head word, decides retirement,
// and flags underflow and double-read events for the current read.
// Assumes one host read per cycle; reads of an empty queue mark nothing.
module rof_lane_track
    import rof_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_en,
    input  logic [1:0] rd_size,
    input  logic [2:0] rd_addr,
    input  logic       empty,
    output logic       pop,
    output logic       ev_undr,
    output logic       ev_dbl
);
    logic [LANES-1:0] used;
    logic [LANES-1:0] sel;
    logic [LANES-1:0] merged;
    logic             live;

    // Decode the lanes touched by this read.
    always_comb begin
        case (rd_size)
            SZ_BYTE: sel = LANES'(1) << rd_addr;
            SZ_QUAD: sel = rd_addr[2] ? 8'hF0 : 8'h0F;
            default: sel = '1;
        endcase
    end

    assign live    = rd_en && !empty;
    assign merged  = used | sel;
    assign pop     = live && (merged == '1);
    assign ev_undr = rd_en && empty;
    assign ev_dbl  = live && ((used & sel) != '0);

    // Accumulate read lanes, clearing when the head word retires.
    always_ff @(posedge clk) begin
        if (!rst_n)     used <= '0;
        else if (pop)   used <= '0;
        else if (live)  used <= merged;
    end

    a_r3_clear_on_pop: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> used == '0);
    a_r3_never_full: assert property (@(posedge clk) disable iff (!rst_n)
        used != '1);
endmodule

// File: rtl/rof_err_unit.sv
// Error status/mask registers with interrupt, halt and channel flag.
// Assumes events are single-cycle pulses; new unmasked events merge on
// top of any register write in the same cycle.
module rof_err_unit
    import rof_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] events,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [STAT_W-1:0] reg_wdata,
    input  logic              chan_assigned,
    output logic [STAT_W-1:0] status,
    output logic [STAT_W-1:0] mask,
    output logic              irq,
    output logic              halted,
    output logic              chan_err
);
    logic [STAT_W-1:0] base;
    logic              wr_stat, wr_clr;

    assign wr_stat = reg_wr && (reg_sel == SEL_STATUS);
    assign wr_clr  = reg_wr && (reg_sel == SEL_CTRL) && reg_wdata[0];

    // Choose the status value before new events are merged.
    always_comb begin
        if (wr_clr)       base = '0;
        else if (wr_stat) base = reg_wdata & ~mask;
        else              base = status;
    end

    // Latch status with unmasked events.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= base | (events & ~mask);
    end

    // Hold the mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)                              mask <= '0;
        else if (reg_wr && reg_sel == SEL_MASK)  mask <= reg_wdata;
    end

    assign irq      = |status;
    assign halted   = irq;
    assign chan_err = chan_assigned && irq;

    a_r7_masked_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((status & ~$past(status) & $past(mask)) == '0));
    a_r9_write_masked: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat && !wr_clr |=> ((status & $past(mask)) == '0));
    a_r10_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr && ((events & ~mask) == '0) |=> status == '0);
endmodule

// File: rtl/rng_out_fifo.sv
// Host-facing output side of a random number generator: a word queue
// filled by a producer, a lane-tracked read port and an error unit.
// Assumes single-cycle host strobes; the producer holds data until ready.
module rng_out_fifo
    import rof_pkg::*;
#(
    parameter int WORD_W = 64,
    parameter int DEPTH  = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         src_valid,
    input  logic [WORD_W-1:0]            src_data,
    output logic                         src_ready,
    input  logic                         rd_en,
    input  logic [1:0]                   rd_size,
    input  logic [2:0]                   rd_addr,
    output logic [WORD_W-1:0]            rd_data,
    input  logic                         q_wr,
    input  logic                         reg_wr,
    input  logic [1:0]                   reg_sel,
    input  logic [STAT_W-1:0]            reg_wdata,
    input  logic                         chan_assigned,
    output logic [STAT_W-1:0]            err_status,
    output logic [STAT_W-1:0]            err_mask,
    output logic                         err_irq,
    output logic                         halted,
    output logic                         chan_err,
    output logic [$clog2(DEPTH+1)-1:0]   level
);
    logic              empty, full, pop, push;
    logic              ev_undr, ev_dbl;
    logic [STAT_W-1:0] events;

    assign src_ready = !full && !halted;
    assign push      = src_valid && src_ready;

    // Gather error events in status bit order.
    always_comb begin
        events           = '0;
        events[BIT_ADDR] = q_wr;
        events[BIT_UNDR] = ev_undr;
        events[BIT_DBL]  = ev_dbl;
    end

    rof_queue #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_queue (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(src_data),
        .pop(pop), .head(rd_data), .empty(empty), .full(full), .count(level)
    );

    rof_lane_track u_track (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_size(rd_size),
        .rd_addr(rd_addr), .empty(empty), .pop(pop),
        .ev_undr(ev_undr), .ev_dbl(ev_dbl)
    );

    rof_err_unit u_err (
        .clk(clk), .rst_n(rst_n), .events(events), .reg_wr(reg_wr),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .chan_assigned(chan_assigned), .status(err_status), .mask(err_mask),
        .irq(err_irq), .halted(halted), .chan_err(chan_err)
    );

    a_r8_halt_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !src_ready);
    a_r8_halt_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> level <= $past(level));
endmodule

// File: tb/tb_rng_out_fifo.sv
module tb_rng_out_fifo;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0, rst_n = 0;
    logic        src_valid = 0;
    logic [63:0] src_data = '0;
    logic        src_ready;
    logic        rd_en = 0;
    logic [1:0]  rd_size = 0;
    logic [2:0]  rd_addr = 0;
    logic [63:0] rd_data;
    logic        q_wr = 0, reg_wr = 0;
    logic [1:0]  reg_sel = 0;
    logic [2:0]  reg_wdata = 0;
    logic        chan_assigned = 0;
    logic [2:0]  err_status, err_mask;
    logic        err_irq, halted, chan_err;
    logic [3:0]  level;

    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rng_out_fifo dut (.*);

    function automatic logic [63:0] wd(int i);
        return {8{8'(8'h30 + i)}};
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(logic [63:0] d);
        @(negedge clk); src_valid = 1; src_data = d;
        @(negedge clk); src_valid = 0;
    endtask

    task automatic rd(logic [1:0] sz, logic [2:0] a);
        @(negedge clk); rd_en = 1; rd_size = sz; rd_addr = a;
        @(negedge clk); rd_en = 0;
    endtask

    task automatic wreg(logic [1:0] s, logic [2:0] d);
        @(negedge clk); reg_wr = 1; reg_sel = s; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic t_reset;
        check("R1 level", 64'(level), 0);
        check("R1 status", 64'(err_status), 0);
        check("R1 mask", 64'(err_mask), 0);
        check("R1 irq/halt/chan", 64'({err_irq, halted, chan_err}), 0);
        check("R1 ready", 64'(src_ready), 1);
        check("R1 rd_data", rd_data, 0);
    endtask

    task automatic t_order;
        push(wd(0)); push(wd(1)); push(wd(2));
        check("R2 level", 64'(level), 3);
        check("R2 head", rd_data, wd(0));
        rd(2'd2, 3'd0);
        check("R3 oct retire", rd_data, wd(1));
        check("R3 oct level", 64'(level), 2);
    endtask

    task automatic t_mixed;
        rd(2'd1, 3'd0);
        check("R3 quad low keeps", 64'(level), 2);
        rd(2'd1, 3'd4);
        check("R3 quad high retires", rd_data, wd(2));
        for (int b = 0; b < 7; b++) rd(2'd0, 3'(b));
        check("R3 seven bytes keep", 64'(level), 1);
        rd(2'd0, 3'd7);
        check("R3 eighth byte retires", 64'(level), 0);
        check("R2 empty data", rd_data, 0);
        check("R4 no false dbl", 64'(err_status), 0);
    endtask

    task automatic t_double;
        push(wd(3));
        rd(2'd0, 3'd3);
        rd(2'd0, 3'd3);
        check("R4 dbl bit", 64'(err_status), 3'b100);
        check("R8 irq", 64'({err_irq, halted}), 2'b11);
        check("R8 ready low", 64'(src_ready), 0);
        check("R11 unassigned", 64'(chan_err), 0);
        chan_assigned = 1;
        #1 check("R11 assigned", 64'(chan_err), 1);
        push(wd(4));
        check("R8 stalled", 64'(level), 1);
        wreg(2'd3, 3'b001);
        check("R10 cleared", 64'(err_status), 0);
        check("R11 clear drops", 64'(chan_err), 0);
        chan_assigned = 0;
        rd(2'd1, 3'd4);
        rd(2'd0, 3'd0); rd(2'd0, 3'd1);
        check("R4 lanes still count", 64'(level), 1);
        rd(2'd0, 3'd2);
        check("R4 retire after dbl", 64'(level), 0);
        check("R4 clean tail", 64'(err_status), 0);
    endtask

    task automatic t_ae_und;
        @(negedge clk); q_wr = 1;
        @(negedge clk); q_wr = 0;
        check("R5 addr bit", 64'(err_status), 3'b001);
        wreg(2'd3, 3'b001);
        rd(2'd2, 3'd0);
        check("R6 underflow bit", 64'(err_status), 3'b010);
        check("R6 level kept", 64'(level), 0);
        wreg(2'd0, 3'b000);
        check("R9 zero write clears", 64'(err_status), 0);
    endtask

    task automatic t_mask;
        wreg(2'd1, 3'b111);
        rd(2'd0, 3'd0);
        @(negedge clk); q_wr = 1;
        @(negedge clk); q_wr = 0;
        check("R7 masked status", 64'(err_status), 0);
        check("R7 masked irq", 64'(err_irq), 0);
        wreg(2'd1, 3'b101);
        check("R7 mask value", 64'(err_mask), 3'b101);
        wreg(2'd0, 3'b111);
        check("R9 masked write", 64'(err_status), 3'b010);
        wreg(2'd3, 3'b001);
        wreg(2'd1, 3'b000);
    endtask

    task automatic t_eom;
        push(wd(5));
        rd(2'd0, 3'd6);
        wreg(2'd2, 3'b111);
        check("R12 status", 64'(err_status), 0);
        check("R12 mask", 64'(err_mask), 0);
        check("R12 head", rd_data, wd(5));
        rd(2'd1, 3'd0);
        rd(2'd0, 3'd4); rd(2'd0, 3'd5);
        check("R12 tracking kept", 64'(level), 1);
        rd(2'd0, 3'd7);
        check("R12 retire", 64'(level), 0);
        check("R12 no dbl", 64'(err_status), 0);
    endtask

    task automatic t_full;
        for (int i = 0; i < 9; i++) push(wd(10 + i));
        check("R13 level full", 64'(level), 8);
        check("R13 ready low", 64'(src_ready), 0);
        rd(2'd2, 3'd0);
        check("R13 after drain", 64'(level), 7);
        check("R13 order", rd_data, wd(11));
        for (int i = 0; i < 7; i++) rd(2'd2, 3'd0);
        check("R13 ninth refused", 64'(level), 0);
        check("R13 status clean", 64'(err_status), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_order();
        t_mixed();
        t_double();
        t_ae_und();
        t_mask();
        t_eom();
        t_full();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule